// File: doc/BRIEF.md
# Pointer-Indexed Control Register Port

This block is the bus-side register access unit of one serial controller channel. The host sees two byte locations in the channel window. The control port is at offset 0 and the data port is at offset 2. Most internal registers are not mapped directly. Software reaches them through a two-step pointer protocol on the control port.

A control write while the pointer is idle carries a register index. The next control access, read or write, goes to the register at that index. After that access the pointer falls back to zero. Write space and read space are separate: the same index names different storage depending on the direction.

The unit decodes the index into one-hot write and read strobes. It muxes read data and holds the configuration bank of write registers. The transmit and receive datapaths consume the strobes and the bank. They also supply the status bytes that the read side returns.

Top module: `sccreg_port`

## Requirements
- R1: A synchronous active-high `rst` clears the pointer (`ptr_busy` = 0) and every byte of `cfg_bank` to 0.
- R2: A control-port write (offset 0) while the pointer is idle does two things. It pulses `wr_strobe[0]`, the command register. It also loads the pointer with index = data[2:0], plus 8 when data[5:3] == 3'b001 (point high, value 0x08). `ptr_busy` rises only when that index is non-zero.
- R3: A control-port write while `ptr_busy` is 1 pulses `wr_strobe[index]` in the same cycle. It stores the byte into `cfg_bank` slot index, unless the index is 0 or 8 (strobe only). From the next cycle the pointer is idle.
- R4: A control-port read while `ptr_busy` is 1 returns read register [index] on `acc_rdata` in the same cycle and pulses `rd_strobe[index]`. From the next cycle the pointer is idle.
- R5: The read map at each index is as follows:
  - 0: `ext_status`, with break 0x80, tx underrun 0x40, CTS 0x20, sync/hunt 0x10, DCD 0x08, tx empty 0x04, zero count 0x02 and rx available 0x01.
  - 1: `rx_cond`.
  - 8: `rx_byte`.
  - 12, 13 and 15: the bytes last written at those same write indices (12 and 13 are the baud time-constant low and high bytes).
  - Every other index reads 0, even where a write register of that index holds a value.
- R6: A control-port read while the pointer is idle returns read register 0 (`ext_status`), pulses `rd_strobe[0]` and leaves the pointer idle.
- R7: A data-port access (offset 2) never changes the pointer. A write there pulses `wr_strobe[8]`. A read there returns `rx_byte` and pulses `rd_strobe[8]`.
- R8: An access at offset 1 or 3 has no effect. It produces no strobe, `acc_rdata` is 0, and the pointer and `cfg_bank` do not change.
- R9: `wr_strobe` and `rd_strobe` each have at most one bit set. Both are combinational in the access cycle, and `wr_value` equals the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Bus access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Byte offset in the channel window |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the access cycle |
| ext_status | input | 8 | Buffer and external status byte (read index 0) |
| rx_cond | input | 8 | Special receive condition byte (read index 1) |
| rx_byte | input | 8 | Received character (read index 8 and data port) |
| wr_strobe | output | 16 | One-hot write strobe per write index |
| wr_value | output | 8 | Byte that goes with `wr_strobe` |
| rd_strobe | output | 16 | One-hot read strobe per read index |
| cfg_bank | output | 128 | Stored write registers, byte i at [8i+7:8i] |
| ptr_busy | output | 1 | Pointer holds a non-zero index awaiting use |

## Verification
Strobes and read data are combinational, so they are due in the same cycle as the access. The monitor samples them one nanosecond after the falling edge on which the driver applied the access. Pointer and bank effects land on the following rising edge. They are therefore judged at the next access through `ptr_busy` and the returned data, or by a bank comparison one falling edge later. Every expected value comes from a bench-side model of the pointer and bank, kept from the requirements and queued by the driver.

// File: rtl/sccreg_port.sv
`timescale 1ns/1ps
module sccreg_port #(
  parameter int          DW          = 8,
  parameter int          NREG        = 16,
  parameter logic [1:0]  CTRL_OFS    = 2'd0,
  parameter logic [1:0]  DATA_OFS    = 2'd2,
  parameter int          HIGH_BASE   = 8,
  parameter int          BUF_IDX     = 8,
  parameter int          COND_IDX    = 1,
  parameter logic [2:0]  PT_HIGH_CMD = 3'b001,
  parameter logic [15:0] RDBACK_MASK = 16'hB000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [1:0]       acc_addr,
  input  logic [DW-1:0]    acc_wdata,
  output logic [DW-1:0]    acc_rdata,
  input  logic [DW-1:0]    ext_status,
  input  logic [DW-1:0]    rx_cond,
  input  logic [DW-1:0]    rx_byte,
  output logic [NREG-1:0]  wr_strobe,
  output logic [DW-1:0]    wr_value,
  output logic [NREG-1:0]  rd_strobe,
  output logic [NREG*DW-1:0] cfg_bank,
  output logic             ptr_busy
);
  localparam int IW = $clog2(NREG);
  localparam logic [IW-1:0] BUF_I  = IW'(BUF_IDX);
  localparam logic [IW-1:0] COND_I = IW'(COND_IDX);

  logic            armed;
  logic [IW-1:0]   ptr;
  logic [DW-1:0]   wreg [NREG];
  logic [DW-1:0]   rr_sel;

  wire ctl_acc = acc_en && (acc_addr == CTRL_OFS);
  wire dat_acc = acc_en && (acc_addr == DATA_OFS);
  wire [IW-1:0] tgt = armed ? ptr : '0;
  wire [IW-1:0] load_idx = IW'(acc_wdata[2:0]) +
                           ((acc_wdata[5:3] == PT_HIGH_CMD) ? IW'(HIGH_BASE) : '0);

  always_comb begin
    wr_strobe = '0;
    rd_strobe = '0;
    if (ctl_acc) begin
      if (acc_wr) wr_strobe[tgt] = 1'b1;
      else        rd_strobe[tgt] = 1'b1;
    end else if (dat_acc) begin
      if (acc_wr) wr_strobe[BUF_I] = 1'b1;
      else        rd_strobe[BUF_I] = 1'b1;
    end
  end

  always_comb begin
    rr_sel = '0;
    if (tgt == '0)               rr_sel = ext_status;
    else if (tgt == COND_I)      rr_sel = rx_cond;
    else if (tgt == BUF_I)       rr_sel = rx_byte;
    else if (RDBACK_MASK[tgt])   rr_sel = wreg[tgt];
  end

  assign acc_rdata = (dat_acc && !acc_wr) ? rx_byte :
                     (ctl_acc && !acc_wr) ? rr_sel  : '0;
  assign wr_value  = acc_wdata;
  assign ptr_busy  = armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      ptr   <= '0;
      for (int i = 0; i < NREG; i++) wreg[i] <= '0;
    end else if (ctl_acc) begin
      if (armed) begin
        armed <= 1'b0;
        ptr   <= '0;
      end else if (acc_wr) begin
        ptr   <= load_idx;
        armed <= (load_idx != '0);
      end
      if (acc_wr && tgt != '0 && tgt != BUF_I) wreg[tgt] <= acc_wdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    assign cfg_bank[g*DW +: DW] = wreg[g];
  end
endmodule

module sccreg_port_chk (
  input logic         clk,
  input logic         rst,
  input logic         acc_en,
  input logic         acc_wr,
  input logic [1:0]   acc_addr,
  input logic [7:0]   acc_rdata,
  input logic [7:0]   ext_status,
  input logic [15:0]  wr_strobe,
  input logic [15:0]  rd_strobe,
  input logic [127:0] cfg_bank,
  input logic         ptr_busy,
  input logic [3:0]   ptr
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cfg_bank == '0 && !ptr_busy && ptr == '0));

  assert_ptr_release_R3: assert property (@(posedge clk) disable iff (rst)
    (ptr_busy && acc_en && acc_addr == 2'd0) |=> !ptr_busy);

  assert_rdback_R5: assert property (@(posedge clk) disable iff (rst)
    (ptr_busy && ptr == 4'd15 && acc_en && !acc_wr && acc_addr == 2'd0)
      |-> acc_rdata == cfg_bank[127:120]);

  assert_idle_read_R6: assert property (@(posedge clk) disable iff (rst)
    (!ptr_busy && acc_en && !acc_wr && acc_addr == 2'd0) |-> acc_rdata == ext_status);

  assert_data_keeps_ptr_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_addr == 2'd2) |=> ($stable(ptr) && $stable(ptr_busy)));

  assert_odd_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_addr[0]) |=> ($stable(cfg_bank) && $stable(ptr)));

  assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_strobe) && $onehot0(rd_strobe) && !(|wr_strobe && |rd_strobe));
endmodule

bind sccreg_port sccreg_port_chk u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
  .acc_rdata(acc_rdata), .ext_status(ext_status), .wr_strobe(wr_strobe),
  .rd_strobe(rd_strobe), .cfg_bank(cfg_bank), .ptr_busy(ptr_busy), .ptr(ptr)
);

// File: tb/sccreg_port_tb.sv
`timescale 1ns/1ps
module sccreg_port_tb;
  logic clk = 0, rst = 1;
  logic acc_en = 0, acc_wr = 0;
  logic [1:0] acc_addr = 0;
  logic [7:0] acc_wdata = 0, acc_rdata, wr_value;
  logic [7:0] ext_status = 8'hA5, rx_cond = 8'h3C, rx_byte = 8'hE7;
  logic [15:0] wr_strobe, rd_strobe;
  logic [127:0] cfg_bank;
  logic ptr_busy;

  always #2.5 clk = ~clk;

  sccreg_port u_dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .ext_status(ext_status),
    .rx_cond(rx_cond), .rx_byte(rx_byte), .wr_strobe(wr_strobe), .wr_value(wr_value),
    .rd_strobe(rd_strobe), .cfg_bank(cfg_bank), .ptr_busy(ptr_busy)
  );

  typedef struct {
    logic [7:0]  rd;
    logic [7:0]  wv;
    logic [15:0] ws;
    logic [15:0] rs;
    logic        busy;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic       m_busy = 0;
  logic [3:0] m_ptr = 0;
  logic [7:0] m_cfg [16];

  function automatic logic [7:0] rmap(input logic [3:0] i);
    if (i == 0) return ext_status;
    if (i == 1) return rx_cond;
    if (i == 8) return rx_byte;
    if (i == 12 || i == 13 || i == 15) return m_cfg[i];
    return 8'h00;
  endfunction

  task automatic clear_model();
    m_busy = 0; m_ptr = 0;
    for (int i = 0; i < 16; i++) m_cfg[i] = 8'h00;
  endtask

  task automatic acc(input logic wr, input logic [1:0] a, input logic [7:0] d, input string req);
    exp_t e;
    logic [3:0] tgt, idx;
    @(negedge clk);
    acc_en = 1; acc_wr = wr; acc_addr = a; acc_wdata = d;
    e.busy = m_busy; e.ws = 0; e.rs = 0; e.rd = 0; e.wv = d; e.req = req;
    tgt = m_busy ? m_ptr : 4'd0;
    if (a == 2'd0) begin
      if (wr) begin
        e.ws[tgt] = 1;
        if (m_busy) begin
          if (tgt != 0 && tgt != 8) m_cfg[tgt] = d;
          m_busy = 0; m_ptr = 0;
        end else begin
          idx = {1'b0, d[2:0]} + ((d[5:3] == 3'b001) ? 4'd8 : 4'd0);
          m_ptr = idx; m_busy = (idx != 0);
        end
      end else begin
        e.rs[tgt] = 1; e.rd = rmap(tgt);
        m_busy = 0; m_ptr = 0;
      end
    end else if (a == 2'd2) begin
      if (wr) e.ws[8] = 1;
      else begin e.rs[8] = 1; e.rd = rx_byte; end
    end
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_en = 0; acc_wr = 0; acc_addr = 0; acc_wdata = 0;
    end
  endtask

  task automatic check_bank(input string req);
    logic [127:0] expv;
    idle(1);
    #1;
    for (int i = 0; i < 16; i++) expv[i*8 +: 8] = m_cfg[i];
    checks++;
    if (cfg_bank !== expv || ptr_busy !== m_busy) begin
      errors++;
      $display("FAIL %s bank: actual %h busy %b expected %h busy %b", req, cfg_bank, ptr_busy, expv, m_busy);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (acc_en && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (acc_rdata !== e.rd || wr_strobe !== e.ws || rd_strobe !== e.rs ||
          ptr_busy !== e.busy || (|e.ws && wr_value !== e.wv)) begin
        errors++;
        $display("FAIL %s: actual rd=%h ws=%h rs=%h busy=%b wv=%h expected rd=%h ws=%h rs=%h busy=%b wv=%h",
                 e.req, acc_rdata, wr_strobe, rd_strobe, ptr_busy, wr_value,
                 e.rd, e.ws, e.rs, e.busy, e.wv);
      end
    end else if (!acc_en) begin
      if (wr_strobe !== 0 || rd_strobe !== 0) begin
        checks++; errors++;
        $display("FAIL R9 idle strobes: actual ws=%h rs=%h expected 0", wr_strobe, rd_strobe);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_model();
    rst = 1; idle(3);
    rst = 0;
    check_bank("R1 reset");

    acc(0, 2'd0, 8'h00, "R6 bare read");
    acc(1, 2'd0, 8'h03, "R2 pointer 3");
    acc(1, 2'd0, 8'hC1, "R3 write 3");
    acc(1, 2'd0, 8'h0C, "R2 point high 12");
    acc(1, 2'd0, 8'h34, "R3 write 12");
    acc(1, 2'd0, 8'h0D, "R2 point high 13");
    acc(1, 2'd0, 8'h12, "R3 write 13");
    acc(1, 2'd0, 8'h0F, "R2 point high 15");
    acc(1, 2'd0, 8'h5A, "R3 write 15");
    acc(1, 2'd0, 8'h0E, "R2 point high 14");
    acc(1, 2'd0, 8'h01, "R3 write 14");
    acc(1, 2'd0, 8'h14, "R2 cmd bits no point high");
    acc(1, 2'd0, 8'h44, "R3 write 4");
    acc(1, 2'd0, 8'h0B, "R2 point high 11");
    acc(1, 2'd0, 8'h9E, "R3 write 11");
    check_bank("R3 bank");

    acc(1, 2'd0, 8'h0C, "R4 ptr 12");
    acc(0, 2'd0, 8'h00, "R5 read 12");
    acc(1, 2'd0, 8'h0D, "R4 ptr 13");
    acc(0, 2'd0, 8'h00, "R5 read 13");
    acc(1, 2'd0, 8'h0F, "R4 ptr 15");
    acc(0, 2'd0, 8'h00, "R5 read 15");
    acc(1, 2'd0, 8'h03, "R4 ptr 3");
    acc(0, 2'd0, 8'h00, "R5 read 3 separate space");
    acc(1, 2'd0, 8'h0E, "R4 ptr 14");
    acc(0, 2'd0, 8'h00, "R5 read 14 zero");
    acc(1, 2'd0, 8'h01, "R4 ptr 1");
    acc(0, 2'd0, 8'h00, "R5 read 1");
    acc(1, 2'd0, 8'h08, "R4 ptr 8");
    acc(0, 2'd0, 8'h00, "R5 read 8");
    acc(0, 2'd0, 8'h00, "R6 read after release");

    acc(1, 2'd0, 8'h05, "R7 ptr 5");
    acc(1, 2'd2, 8'h77, "R7 data write");
    acc(0, 2'd2, 8'h00, "R7 data read");
    acc(1, 2'd0, 8'h99, "R7 pointer kept");
    check_bank("R7 bank");

    acc(1, 2'd0, 8'h0C, "R8 ptr 12");
    acc(1, 2'd1, 8'hFF, "R8 offset 1 write");
    acc(0, 2'd3, 8'h00, "R8 offset 3 read");
    acc(1, 2'd3, 8'hEE, "R8 offset 3 write");
    acc(0, 2'd0, 8'h00, "R8 pointer kept");
    check_bank("R8 bank");

    acc(1, 2'd0, 8'h08, "R9 ptr 8");
    acc(1, 2'd0, 8'h42, "R9 write 8 strobe only");
    acc(1, 2'd0, 8'h00, "R2 zero index stays idle");
    acc(0, 2'd0, 8'h00, "R6 read after zero index");
    check_bank("R9 bank");

    acc(1, 2'd0, 8'h0D, "R1 arm before reset");
    idle(1);
    rst = 1; idle(1); rst = 0;
    clear_model();
    check_bank("R1 mid reset");
    acc(0, 2'd0, 8'h00, "R1 idle after reset");

    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule